// File: doc/BRIEF.md
# Vectored Interrupt Controller with Banked Masks

This block collects 96 level-sensitive interrupt lines, arranged as three banks of 32, and chooses one of them to present to a processor. Software reaches it over a plain 32-bit register bus with a valid strobe, a byte address, a write enable and write data. Read data comes back registered, one clock after the read request.

Each line can be masked, and has a 6-bit priority of its own. A global threshold can hide lines whose priority is too low. When no line is held, the controller picks the best unmasked, eligible, pending line and latches its number. It raises `irq_out` and keeps that number frozen in the active register until software writes an acknowledge. Masks change only through a set alias and a clear alias per bank. A masked pending view of each bank can be read back.

A soft reset, started by software, returns every register to its default over a fixed number of cycles. A status bit reports when the reset has completed. A read-only revision byte identifies the block.

Top module: `vic_top`

## Requirements
- R1: Address 0x000 reads the revision byte {major[3:0], minor[3:0]} in bits [7:0], 0x40 by default. Any address that maps to no register reads 0.
- R2: After reset every mask bit is 1 and every priority is 0. The threshold reads 0xFF, the configuration register reads 0, the done bit reads 1, the active register reads 0 and `irq_out` is low.
- R3: Per bank b, a 1 written to the set alias at 0x08C+0x20*b masks that line, and a 1 written to the clear alias at 0x088+0x20*b unmasks it. Bit i of each alias stands for line 32*b+i. Bits written as 0 change nothing. The mask register at 0x084+0x20*b reads the current mask, and writes to it are ignored.
- R4: Address 0x098+0x20*b reads the bank's lines ANDed with the inverse of its mask, with bit i standing for line 32*b+i.
- R5: When no number is held, the clock edge after an eligible unmasked line is pending latches the line with the numerically lowest priority. A tie goes to the lowest line number. `irq_out` is high exactly while a number is held.
- R6: The threshold register at 0x068 (bits [7:0]) makes a line eligible only if its priority is numerically below the threshold. The value 0xFF makes every line eligible.
- R7: The active register at 0x040 holds the latched line number in bits [6:0], with all other bits 0. It stays unchanged while the number is held, even if the line drops or is masked, and reads 0 when nothing is held.
- R8: Writing a 1 in bit 0 of the control register at 0x048 releases the held number. `irq_out` is low in the cycle after that write, and a new winner can latch on the next edge. A write with bit 0 clear has no effect.
- R9: Line n has a priority register at 0x100+4*n holding its priority in bits [7:2]. Bits [1:0] and [31:8] read 0.
- R10: Bit 0 of the configuration register at 0x010 (the automatic idle enable) is stored and read back. Bit 0 of the status register at 0x014 reads the reset-done flag.
- R11: Writing 1 to bit 1 of 0x010 starts a soft reset of 4 cycles. During it the done bit reads 0, bus writes are ignored and every register goes back to its R2 default. The done bit reads 1 again after the reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_lines | input | 96 | Level-sensitive interrupt inputs |
| irq_out | output | 1 | Interrupt to the processor, high while a winner is held |

## Verification
The bench sets up priority ties, the threshold at its edges (0, 1 and a value between two priorities) and a winner whose line drops or gets masked while held. A design that breaks ties on the highest index, or uses a less-or-equal threshold compare, names the wrong line. A design that re-arbitrates continuously lets the active number drift before the acknowledge. It also acknowledges while the winning line stays high, to confirm the one-cycle low gap on `irq_out` and the re-latch, and it issues an acknowledge with bit 0 clear, which must leave the winner alone. A soft reset is issued with state set everywhere and a write placed inside its window. A counter that is one off, or a reset that does not block writes, leaves the done bit or a register at the wrong value. Randomised rounds then compare masks, priorities, thresholds and lines against a reference model of the arbitration.

// File: rtl/vic_pkg.sv
package vic_pkg;

    // register map (byte addresses)
    localparam logic [11:0] A_REV       = 12'h000;
    localparam logic [11:0] A_CFG       = 12'h010;
    localparam logic [11:0] A_STAT      = 12'h014;
    localparam logic [11:0] A_ACT       = 12'h040;
    localparam logic [11:0] A_CTRL      = 12'h048;
    localparam logic [11:0] A_THR       = 12'h068;
    localparam logic [11:0] A_MASK      = 12'h084;
    localparam logic [11:0] A_MCLR      = 12'h088;
    localparam logic [11:0] A_MSET      = 12'h08C;
    localparam logic [11:0] A_PEND      = 12'h098;
    localparam logic [11:0] A_PRIO      = 12'h100;
    localparam logic [11:0] BANK_STRIDE = 12'h020;

    localparam int ACT_W = 7;

    typedef struct packed {
        logic             held;
        logic [ACT_W-1:0] line;
    } win_t;

    function automatic logic [11:0] bank_addr(input logic [11:0] base, input int b);
        return base + 12'(b) * BANK_STRIDE;
    endfunction

    function automatic logic lvl_ok(input logic [7:0] p, input logic [7:0] t);
        return (t == 8'hFF) || (p < t);
    endfunction

endpackage

// File: rtl/vic_srst.sv
module vic_srst #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/vic_mask_bank.sv
module vic_mask_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst)
            mask <= '1;
        else if (set_en)
            mask <= mask | bits;
        else if (clr_en)
            mask <= mask & ~bits;
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int N  = 96,
    parameter int PW = 6
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio_flat,
    input  logic [7:0]      thr,
    output logic            found,
    output logic [ACT_W-1:0] win
);
    always_comb begin
        logic [PW-1:0] best;
        logic [PW-1:0] cur;
        found = 1'b0;
        win   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            cur = prio_flat[i*PW +: PW];
            // strict compare keeps the earlier (lower) index on a tie
            if (req[i] && lvl_ok(8'(cur), thr) && (!found || cur < best)) begin
                found = 1'b1;
                best  = cur;
                win   = ACT_W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NUM_LINES   = 96,
    parameter int LINE_W      = 32,
    parameter int PRIO_W      = 6,
    parameter int SRST_CYCLES = 4,
    parameter int REV_MAJOR   = 4,
    parameter int REV_MINOR   = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_we,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_lines,
    output logic                 irq_out
);
    localparam int NUM_BANKS = NUM_LINES / LINE_W;
    localparam logic [9:0] PRIO_CNT = 10'(NUM_LINES);
    localparam logic [7:0] REV_BYTE = {4'(REV_MAJOR), 4'(REV_MINOR)};

    logic srst_busy, lrst, wr, rd, srst_go, ack;
    logic [NUM_LINES-1:0] mask_flat, pend_flat;
    logic [NUM_LINES*PRIO_W-1:0] prio_flat;
    logic [PRIO_W-1:0] prio_q [NUM_LINES];
    logic [7:0] thr_q;
    logic       idle_en_q;
    win_t       win_q;
    logic       arb_found;
    logic [ACT_W-1:0] arb_line;
    logic [11:0] prio_off;
    logic        prio_hit;
    logic [ACT_W-1:0] prio_idx;
    logic [31:0] rd_val;

    assign wr      = bus_valid && bus_we && !srst_busy;
    assign rd      = bus_valid && !bus_we;
    assign lrst    = rst || srst_busy;
    assign srst_go = wr && (bus_addr == A_CFG) && bus_wdata[1];
    assign ack     = wr && (bus_addr == A_CTRL) && bus_wdata[0];

    assign prio_off = bus_addr - A_PRIO;
    assign prio_hit = (bus_addr >= A_PRIO) && (prio_off[11:2] < PRIO_CNT) && (prio_off[1:0] == 2'b00);
    assign prio_idx = prio_off[2 +: ACT_W];

    vic_srst #(.CYC(SRST_CYCLES)) u_srst (
        .clk(clk), .rst(rst), .start(srst_go), .busy(srst_busy)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        vic_mask_bank #(.W(LINE_W)) u_mask (
            .clk    (clk),
            .rst    (lrst),
            .set_en (wr && (bus_addr == bank_addr(A_MSET, b))),
            .clr_en (wr && (bus_addr == bank_addr(A_MCLR, b))),
            .bits   (bus_wdata[LINE_W-1:0]),
            .mask   (mask_flat[b*LINE_W +: LINE_W])
        );
    end

    assign pend_flat = irq_lines & ~mask_flat;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_pflat
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end

    always_ff @(posedge clk) begin
        if (lrst) begin
            for (int i = 0; i < NUM_LINES; i++) prio_q[i] <= '0;
            thr_q     <= 8'hFF;
            idle_en_q <= 1'b0;
        end else if (wr) begin
            if (prio_hit)           prio_q[prio_idx] <= bus_wdata[2 +: PRIO_W];
            if (bus_addr == A_THR)  thr_q            <= bus_wdata[7:0];
            if (bus_addr == A_CFG)  idle_en_q        <= bus_wdata[0];
        end
    end

    vic_arbiter #(.N(NUM_LINES), .PW(PRIO_W)) u_arb (
        .req(pend_flat), .prio_flat(prio_flat), .thr(thr_q),
        .found(arb_found), .win(arb_line)
    );

    always_ff @(posedge clk) begin
        if (lrst || ack)
            win_q <= '0;
        else if (!win_q.held && arb_found)
            win_q <= '{held: 1'b1, line: arb_line};
    end

    assign irq_out = win_q.held;

    always_comb begin
        rd_val = '0;
        if (bus_addr == A_REV)  rd_val = 32'(REV_BYTE);
        if (bus_addr == A_CFG)  rd_val = 32'(idle_en_q);
        if (bus_addr == A_STAT) rd_val = 32'(!srst_busy);
        if (bus_addr == A_ACT)  rd_val = 32'(win_q.line);
        if (bus_addr == A_THR)  rd_val = 32'(thr_q);
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == bank_addr(A_MASK, b)) rd_val = 32'(mask_flat[b*LINE_W +: LINE_W]);
            if (bus_addr == bank_addr(A_PEND, b)) rd_val = 32'(pend_flat[b*LINE_W +: LINE_W]);
        end
        if (prio_hit) rd_val = 32'({prio_q[prio_idx], 2'b00});
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (rd)
            bus_rdata <= rd_val;
    end
endmodule

// File: rtl/vic_checks.sv
module vic_checks
    import vic_pkg::*;
#(
    parameter int N = 96,
    parameter int W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_valid,
    input logic             bus_we,
    input logic [11:0]      bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             irq_out,
    input logic [ACT_W-1:0] act_id,
    input logic [N-1:0]     mask_flat,
    input logic [N-1:0]     pend_flat,
    input logic             srst_busy
);
    localparam int NB = N / W;

    logic wr_ok, ack_w, srst_w;
    logic [N-1:0] pend_d;

    assign wr_ok  = bus_valid && bus_we && !srst_busy;
    assign ack_w  = wr_ok && (bus_addr == A_CTRL) && bus_wdata[0];
    assign srst_w = wr_ok && (bus_addr == A_CFG) && bus_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) pend_d <= '0;
        else     pend_d <= pend_flat;
    end

    // R7: a held number does not move until acknowledged
    a_r7_winner_frozen: assert property (@(posedge clk) disable iff (rst)
        irq_out && !ack_w && !srst_w && !srst_busy |=> irq_out && $stable(act_id));

    // R8: acknowledge drops the interrupt on the next cycle
    a_r8_ack_drops: assert property (@(posedge clk) disable iff (rst)
        ack_w |=> !irq_out);

    // R5: a newly latched number was pending and unmasked the cycle before
    a_r5_winner_pending: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> pend_d[act_id]);

    // R11: soft reset restores all masks and releases the interrupt
    a_r11_srst_defaults: assert property (@(posedge clk) disable iff (rst)
        srst_busy |=> (mask_flat == '1) && !irq_out);

    for (genvar b = 0; b < NB; b++) begin : g_chk
        // R3: set alias masks exactly the ones written
        a_r3_set_alias: assert property (@(posedge clk) disable iff (rst)
            wr_ok && (bus_addr == bank_addr(A_MSET, b)) |=>
            ((mask_flat[b*W +: W] & $past(bus_wdata[W-1:0])) == $past(bus_wdata[W-1:0])));
        // R3: clear alias unmasks exactly the ones written
        a_r3_clr_alias: assert property (@(posedge clk) disable iff (rst)
            wr_ok && (bus_addr == bank_addr(A_MCLR, b)) |=>
            ((mask_flat[b*W +: W] & $past(bus_wdata[W-1:0])) == '0));
    end
endmodule

bind vic_top vic_checks #(.N(NUM_LINES), .W(LINE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .act_id    (win_q.line),
    .mask_flat (mask_flat),
    .pend_flat (pend_flat),
    .srst_busy (srst_busy)
);

// File: tb/sim_vic_top.sv
module sim_vic_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [95:0] irq_lines = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [5:0]  m_prio [96];
    logic [95:0] m_mask;
    logic [7:0]  m_thr;

    always #2 clk = ~clk;

    vic_top u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq_lines), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    function automatic logic [7:0] model_win(input logic [95:0] ln, input logic [95:0] mk,
                                             input logic [7:0] th);
        logic [7:0] r;
        logic [5:0] best;
        r = 8'h00; best = '1;
        for (int i = 0; i < 96; i++) begin
            if (ln[i] && !mk[i] && (th == 8'hFF || {2'b00, m_prio[i]} < th)
                && (!r[7] || m_prio[i] < best)) begin
                r = {1'b1, 7'(i)};
                best = m_prio[i];
            end
        end
        return r;
    endfunction

    function automatic logic [95:0] bit_of(input int n);
        return 96'b1 << n;
    endfunction

    // clear any held winner, then present lines and check the result
    task automatic arb_check(input string req, input logic [95:0] ln, input logic v, input int id);
        irq_lines = '0;
        wr(12'h048, 32'h1);
        irq_lines = ln;
        @(negedge clk); @(negedge clk);
        chk(req, {31'b0, irq_out}, {31'b0, v});
        rd_chk(req, 12'h040, v ? 32'(id) : 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4417));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 / R1 / R10: reset state
        chk("R2 irq_out", {31'b0, irq_out}, 32'h0);
        rd_chk("R1 revision", 12'h000, 32'h40);
        rd_chk("R1 unmapped", 12'h020, 32'h0);
        rd_chk("R10 done after reset", 12'h014, 32'h1);
        rd_chk("R2 config", 12'h010, 32'h0);
        rd_chk("R2 mask bank0", 12'h084, 32'hFFFF_FFFF);
        rd_chk("R2 mask bank2", 12'h0C4, 32'hFFFF_FFFF);
        rd_chk("R2 threshold", 12'h068, 32'hFF);
        rd_chk("R2 prio line95", 12'h27C, 32'h0);
        rd_chk("R7 active idle", 12'h040, 32'h0);

        // R3: mask aliases on bank 1
        wr(12'h0A8, 32'h0000_F0F0);
        rd_chk("R3 clear alias", 12'h0A4, 32'hFFFF_0F0F);
        wr(12'h0AC, 32'h0000_0010);
        rd_chk("R3 set alias", 12'h0AC - 12'h8, 32'hFFFF_0F1F);
        wr(12'h0A4, 32'h0);
        rd_chk("R3 direct write ignored", 12'h0A4, 32'hFFFF_0F1F);
        wr(12'h0AC, 32'h0);
        rd_chk("R3 zero bits no effect", 12'h0A4, 32'hFFFF_0F1F);
        wr(12'h0AC, 32'hFFFF_FFFF);

        // R4 / R5: pending view and latch timing
        irq_lines = {64'h0, 32'h0000_0F0C};
        wr(12'h088, 32'h0000_00FF);
        chk("R5 not yet latched", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R5 latched", {31'b0, irq_out}, 32'h1);
        rd_chk("R4 pending bank0", 12'h098, 32'h0000_000C);
        rd_chk("R4 pending bank1 masked", 12'h0B8, 32'h0);
        rd_chk("R5 tie lowest line", 12'h040, 32'h2);

        // R7: frozen while held
        irq_lines = '0;
        rd_chk("R7 line dropped", 12'h040, 32'h2);
        wr(12'h08C, 32'h4);
        rd_chk("R7 line masked", 12'h040, 32'h2);
        chk("R7 irq still held", {31'b0, irq_out}, 32'h1);

        // R8: acknowledge
        wr(12'h048, 32'h2);
        chk("R8 bit0 clear no effect", {31'b0, irq_out}, 32'h1);
        wr(12'h048, 32'h1);
        chk("R8 ack drops irq", {31'b0, irq_out}, 32'h0);
        rd_chk("R7 active after ack", 12'h040, 32'h0);

        // R9 / R5: priorities
        for (int b = 0; b < 3; b++) wr(12'h088 + 12'(b * 32), 32'hFFFF_FFFF);
        wr(12'h1A0, 32'h0000_000B);
        rd_chk("R9 prio readback", 12'h1A0, 32'h08);
        wr(12'h218, 32'h0000_0004);
        arb_check("R5 lower prio wins", bit_of(40) | bit_of(70), 1'b1, 70);
        arb_check("R5 prio zero wins", bit_of(5) | bit_of(40) | bit_of(70), 1'b1, 5);
        arb_check("R5 tie lowest index", bit_of(10) | bit_of(20), 1'b1, 10);

        // R8: re-latch after ack while the line stays high
        arb_check("R5 setup", bit_of(70), 1'b1, 70);
        wr(12'h048, 32'h1);
        chk("R8 gap cycle", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R8 relatch", {31'b0, irq_out}, 32'h1);
        rd_chk("R8 relatch line", 12'h040, 32'd70);

        // R6: threshold
        wr(12'h068, 32'h2);
        arb_check("R6 thr2", bit_of(40) | bit_of(70), 1'b1, 70);
        arb_check("R6 thr2 prio0", bit_of(5) | bit_of(70), 1'b1, 5);
        wr(12'h068, 32'h1);
        arb_check("R6 thr1 none", bit_of(40) | bit_of(70), 1'b0, 0);
        wr(12'h068, 32'h0);
        arb_check("R6 thr0 none", bit_of(5), 1'b0, 0);
        wr(12'h068, 32'hFF);

        // R10: configuration readback
        wr(12'h010, 32'h1);
        rd_chk("R10 autoidle", 12'h010, 32'h1);

        // R11: soft reset
        wr(12'h068, 32'h5);
        arb_check("R11 setup", bit_of(70), 1'b1, 70);
        wr(12'h010, 32'h3);
        rd_chk("R11 busy", 12'h014, 32'h0);
        wr(12'h068, 32'h33);
        irq_lines = '0;
        repeat (4) @(negedge clk);
        rd_chk("R11 done", 12'h014, 32'h1);
        rd_chk("R11 thr default", 12'h068, 32'hFF);
        rd_chk("R11 mask default", 12'h0C4, 32'hFFFF_FFFF);
        rd_chk("R11 cfg default", 12'h010, 32'h0);
        rd_chk("R11 active default", 12'h040, 32'h0);
        rd_chk("R11 prio default", 12'h1A0, 32'h0);
        chk("R11 irq low", {31'b0, irq_out}, 32'h0);

        // randomised rounds against the model
        for (int t = 0; t < 30; t++) begin
            logic [7:0]  e;
            logic [95:0] ln;
            irq_lines = '0;
            wr(12'h048, 32'h1);
            for (int b = 0; b < 3; b++) begin
                logic [31:0] mk;
                mk = $urandom & $urandom;
                wr(12'h08C + 12'(b * 32), 32'hFFFF_FFFF);
                wr(12'h088 + 12'(b * 32), ~mk);
                m_mask[b*32 +: 32] = mk;
            end
            for (int i = 0; i < 96; i++) begin
                m_prio[i] = 6'($urandom % 8);
                wr(12'h100 + 12'(i * 4), {24'b0, m_prio[i], 2'b00});
            end
            m_thr = ($urandom % 4 == 0) ? 8'($urandom % 9) : 8'hFF;
            wr(12'h068, {24'b0, m_thr});
            ln = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
                  $urandom & $urandom & $urandom};
            irq_lines = ln;
            @(negedge clk); @(negedge clk);
            e = model_win(ln, m_mask, m_thr);
            chk("R5 random irq", {31'b0, irq_out}, {31'b0, e[7]});
            rd_chk("R6 random winner", 12'h040, e[7] ? {25'b0, e[6:0]} : 32'h0);
            rd_chk("R4 random pending", 12'h098 + 12'((t % 3) * 32),
                   ln[(t % 3)*32 +: 32] & ~m_mask[(t % 3)*32 +: 32]);
            irq_lines = '0;
            @(negedge clk);
            rd_chk("R7 random frozen", 12'h040, e[7] ? {25'b0, e[6:0]} : 32'h0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule